// File: doc/BRIEF.md
# Standby Residency Counter and Latency Gating

This block decides when the system is in its deepest standby state and measures how long it stays there. Four idle status bits come in from outside: the CPU package is in its deepest C-state, the hub is in low-power mode, the serial PHY lanes are power-gated and the PLLs are idle. When all four are high in the same cycle, the block raises a deep-sleep signal. Any agent that asserts a latency requirement can hold that signal low, unless software has set that agent's bit in an ignore mask.

While deep sleep holds, a prescaler divides the system clock into 100 microsecond ticks. Each complete tick advances a residency counter. The prescaler restarts whenever deep sleep drops, so partial intervals are never counted.

Software reaches the counter and the mask through a 32-bit register port that decodes byte offsets inside a 4 KB window. Read data appears one cycle after the read strobe. A lock input closes the window: while it is high, every read returns all ones and every write is dropped.

Top module: `standby_residency_unit`

## Requirements
- R1: `deep_sleep` is 1 only in a cycle where `cpu_deepest`, `hub_lowpwr`, `phy_gated` and `pll_idle` are all 1 and no agent vetoes (see R4); it responds combinationally to those inputs.
- R2: The residency counter increases by one at the end of every TICK_CYC = CLK_KHZ*TICK_US/1000 consecutive cycles with `deep_sleep` high. With the default 100 MHz and 100 us this is one step per 100 us.
- R3: The counter is CNT_W bits wide (default 32). It wraps from all ones to zero with no other effect, and it reads zero-extended at byte offset 0x13C.
- R4: Agent i vetoes deep sleep when `lat_req[i]` is 1 and mask bit i is 0. A mask bit of 1 makes that agent's request have no effect.
- R5: The ignore mask is read and written at byte offset 0x30C and resets to 0. A write keeps `bus_wdata[N_AGENTS-1:0]` (bits 0 to 16 by default) and forces reserved bit 5 to 0, so agent 5 can never be ignored. Bits 17 to 31 read as 0.
- R6: The prescaler is cleared in every cycle where `deep_sleep` is low, so an interval shorter than TICK_CYC cycles never adds to the counter, however many such intervals occur.
- R7: While `win_lock` is 1, every read returns 0xFFFFFFFF, whatever the offset.
- R8: While `win_lock` is 1, writes are ignored and the mask keeps its value.
- R9: A read (`bus_sel`=1, `bus_wr`=0) gives `bus_rvalid`=1 with `bus_rdata` on the next cycle. Writes raise no `bus_rvalid`. Any offset other than exactly 0x13C or 0x30C reads as 0 when the window is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_lock | input | 1 | Closes the register window |
| cpu_deepest | input | 1 | CPU package in its deepest C-state |
| hub_lowpwr | input | 1 | Hub in low-power mode |
| phy_gated | input | 1 | Serial PHY lanes power-gated |
| pll_idle | input | 1 | PLLs idle |
| lat_req | input | N_AGENTS (17) | Per-agent active latency requirement |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| deep_sleep | output | 1 | Qualified deepest-standby indication |

## Verification
The bench uses a short tick and a 4-bit counter, so it can reach the tick boundary and the wrap point in a few hundred cycles. It holds deep sleep for runs just below a tick, several times over. A prescaler that is not cleared on exit would accumulate these runs into a false step. It drives 120 sleep cycles from a count of 4 to expect exactly 0, which catches a counter that saturates or carries into bit 4. It writes all ones to the mask while agent 5 is requesting: a design that stored the reserved bit would let deep sleep through, and one that stored the upper bits would read back more than 0x1FFDF. Locked reads at mapped and unmapped offsets, followed by a locked write and an unlocked read-back, catch a design that still decodes or stores while the window is closed.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam int WORD_W = 32;
   localparam int ADDR_W = 12;
   typedef logic [WORD_W-1:0] word_t;
   typedef logic [ADDR_W-1:0] ofs_t;
   localparam ofs_t OFS_RESIDENCY = 12'h13C;
   localparam ofs_t OFS_IGNORE    = 12'h30C;
endpackage

// File: rtl/sr_gate.sv
module sr_gate #(
   parameter int N_AGENTS = 17
) (
   input  logic                cpu_deepest,
   input  logic                hub_lowpwr,
   input  logic                phy_gated,
   input  logic                pll_idle,
   input  logic [N_AGENTS-1:0] lat_req,
   input  logic [N_AGENTS-1:0] ign_mask,
   output logic                sleep_ok
);
   logic all_idle;
   logic veto;

   assign all_idle = cpu_deepest & hub_lowpwr & phy_gated & pll_idle;
   assign veto     = |(lat_req & ~ign_mask);
   assign sleep_ok = all_idle & ~veto;
endmodule

// File: rtl/sr_ticker.sv
module sr_ticker #(
   parameter int CLK_KHZ = 100_000,
   parameter int TICK_US = 100,
   parameter int CNT_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_ok,
   output logic [CNT_W-1:0] residency
);
   localparam int TICK_CYC = CLK_KHZ * TICK_US / 1000;
   localparam int PW       = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

   if (TICK_CYC < 1) begin : g_bad_tick
      $error("sr_ticker: tick shorter than one clock");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("sr_ticker: CNT_W must be 1..32");
   end

   logic [PW-1:0]    presc_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         presc_q <= '0;
         cnt_q   <= '0;
      end else if (!sleep_ok) begin
         presc_q <= '0;
      end else if (presc_q == LAST) begin
         presc_q <= '0;
         cnt_q   <= cnt_q + CNT_W'(1);
      end else begin
         presc_q <= presc_q + PW'(1);
      end
   end

   assign residency = cnt_q;

   // R2
   cnt_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> $past(sleep_ok));

   // R3
   cnt_step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   // R6
   presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_ok |=> (presc_q == '0));
endmodule

// File: rtl/sr_regport.sv
module sr_regport
   import sr_pkg::*;
#(
   parameter int N_AGENTS = 17,
   parameter int RSVD_BIT = 5,
   parameter int CNT_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                win_lock,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  ofs_t                bus_addr,
   input  word_t               bus_wdata,
   input  logic [CNT_W-1:0]    residency,
   output logic [N_AGENTS-1:0] ign_mask,
   output word_t               bus_rdata,
   output logic                bus_rvalid
);
   if (N_AGENTS < 1 || N_AGENTS > 31) begin : g_bad_agents
      $error("sr_regport: N_AGENTS must be 1..31");
   end

   logic [N_AGENTS-1:0] mask_q;
   logic [N_AGENTS-1:0] mask_in;
   word_t               cnt_word;
   word_t               mask_word;
   word_t               rd_mux;
   logic                hit_res, hit_ign, rd_req, wr_ok;
   logic                unused_hi;

   for (genvar i = 0; i < N_AGENTS; i++) begin : g_mbit
      if (i == RSVD_BIT) begin : g_rsvd
         assign mask_in[i] = 1'b0;
      end else begin : g_keep
         assign mask_in[i] = bus_wdata[i];
      end
   end
   assign unused_hi = ^bus_wdata[WORD_W-1:N_AGENTS];

   if (CNT_W == WORD_W) begin : g_cnt_full
      assign cnt_word = residency;
   end else begin : g_cnt_ext
      assign cnt_word = {{(WORD_W-CNT_W){1'b0}}, residency};
   end
   assign mask_word = {{(WORD_W-N_AGENTS){1'b0}}, mask_q};

   assign hit_res = (bus_addr == OFS_RESIDENCY);
   assign hit_ign = (bus_addr == OFS_IGNORE);
   assign rd_req  = bus_sel & ~bus_wr;
   assign wr_ok   = bus_sel & bus_wr & ~win_lock & hit_ign;

   always_comb begin
      if (win_lock)     rd_mux = '1;
      else if (hit_res) rd_mux = cnt_word;
      else if (hit_ign) rd_mux = mask_word;
      else              rd_mux = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q     <= '0;
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd_req;
         if (rd_req) bus_rdata <= rd_mux;
         if (wr_ok)  mask_q    <= mask_in;
      end
   end

   assign ign_mask = mask_q;

   // R7
   locked_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_lock && rd_req) |=> (bus_rdata == '1));

   // R8
   locked_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_lock |=> $stable(mask_q));

   // R9
   rvalid_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(rd_req));

   // R5
   rsvd_never_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && bus_wdata[RSVD_BIT]) |=> (mask_q[RSVD_BIT] == 1'b0));
endmodule

// File: rtl/standby_residency_unit.sv
module standby_residency_unit
   import sr_pkg::*;
#(
   parameter int CLK_KHZ  = 100_000,
   parameter int TICK_US  = 100,
   parameter int CNT_W    = 32,
   parameter int N_AGENTS = 17,
   parameter int RSVD_BIT = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                win_lock,
   input  logic                cpu_deepest,
   input  logic                hub_lowpwr,
   input  logic                phy_gated,
   input  logic                pll_idle,
   input  logic [N_AGENTS-1:0] lat_req,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [11:0]         bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                bus_rvalid,
   output logic                deep_sleep
);
   logic [N_AGENTS-1:0] ign_mask;
   logic [CNT_W-1:0]    residency;

   sr_gate #(.N_AGENTS(N_AGENTS)) u_gate (
      .cpu_deepest(cpu_deepest), .hub_lowpwr(hub_lowpwr),
      .phy_gated(phy_gated),     .pll_idle(pll_idle),
      .lat_req(lat_req),         .ign_mask(ign_mask),
      .sleep_ok(deep_sleep)
   );

   sr_ticker #(.CLK_KHZ(CLK_KHZ), .TICK_US(TICK_US), .CNT_W(CNT_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .sleep_ok(deep_sleep), .residency(residency)
   );

   sr_regport #(.N_AGENTS(N_AGENTS), .RSVD_BIT(RSVD_BIT), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .win_lock(win_lock),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .residency(residency), .ign_mask(ign_mask),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
   );

   // R1
   sleep_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deep_sleep |-> (cpu_deepest && hub_lowpwr && phy_gated && pll_idle));

   // R4
   sleep_no_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deep_sleep |-> ((lat_req & ~ign_mask) == '0));
endmodule

// File: tb/standby_residency_unit_test.sv
module standby_residency_unit_test;
   localparam int N = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          win_lock = 1'b0;
   logic          cpu_deepest = 1'b0, hub_lowpwr = 1'b0, phy_gated = 1'b0, pll_idle = 1'b0;
   logic [N-1:0]  lat_req = '0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic          deep_sleep;

   int checks = 0;
   int failures = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   // tick = 100 kHz * 100 us / 1000 = 10 cycles; 4-bit counter
   standby_residency_unit #(.CLK_KHZ(100), .TICK_US(100), .CNT_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .win_lock(win_lock),
      .cpu_deepest(cpu_deepest), .hub_lowpwr(hub_lowpwr),
      .phy_gated(phy_gated), .pll_idle(pll_idle), .lat_req(lat_req),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .deep_sleep(deep_sleep)
   );

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R9 unexpected rvalid actual=%h expected=none", bus_rdata);
         end else begin
            check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_idle(input logic [3:0] v);
      {cpu_deepest, hub_lowpwr, phy_gated, pll_idle} = v;
   endtask

   task automatic hold_sleep(input int n);
      @(negedge clk);
      set_idle(4'hF);
      repeat (n) @(posedge clk);
      @(negedge clk);
      set_idle(4'h0);
   endtask

   task automatic finish_run();
      check(32'(exp_q.size()), 32'd0, "R9 pending reads drained");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(32'(bus_rvalid), 32'd0, "R9 reset rvalid");
      check(32'(deep_sleep), 32'd0, "R1 reset deep_sleep");
      rd(12'h13C, 32'h0, "R3 counter resets to 0");
      rd(12'h30C, 32'h0, "R5 mask resets to 0");
      rd(12'h000, 32'h0, "R9 unmapped reads zero");
      rd(12'h13D, 32'h0, "R9 misaligned offset unmapped");
      wr(12'h13C, 32'h5);
      check(32'(bus_rvalid), 32'd0, "R9 write gives no rvalid");

      // R1: each single missing condition blocks deep sleep
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); set_idle(4'hF & ~(4'h1 << k)); #1;
         check(32'(deep_sleep), 32'd0, "R1 one idle input low");
      end
      @(negedge clk); set_idle(4'hF); #1;
      check(32'(deep_sleep), 32'd1, "R1 all idle inputs high");
      @(negedge clk); set_idle(4'h0);

      // R2 / R6
      hold_sleep(35);
      rd(12'h13C, 32'd3, "R2 35 cycles give 3 ticks");
      hold_sleep(9); hold_sleep(9); hold_sleep(9);
      rd(12'h13C, 32'd3, "R6 partial intervals dropped");
      hold_sleep(10);
      rd(12'h13C, 32'd4, "R2 exact tick counted");

      // R3 wrap: 4 + 12 = 16 -> 0 in 4 bits
      hold_sleep(120);
      rd(12'h13C, 32'd0, "R3 counter wraps to zero");
      hold_sleep(10);
      rd(12'h13C, 32'd1, "R3 counts on after wrap");

      // R4 veto and masking
      @(negedge clk); lat_req = 17'h00004; set_idle(4'hF); #1;
      check(32'(deep_sleep), 32'd0, "R4 unmasked agent vetoes");
      wr(12'h30C, 32'h0000_0004); #1;
      check(32'(deep_sleep), 32'd1, "R4 masked agent ignored");
      rd(12'h30C, 32'h0000_0004, "R5 mask read back");
      @(negedge clk); lat_req = 17'h00020;
      wr(12'h30C, 32'hFFFF_FFFF); #1;
      check(32'(deep_sleep), 32'd0, "R5 reserved agent 5 cannot be masked");
      rd(12'h30C, 32'h0001_FFDF, "R5 mask keeps bits 0-16 minus 5");
      @(negedge clk); lat_req = 17'h1FFDF; #1;
      check(32'(deep_sleep), 32'd1, "R4 all maskable agents ignored");
      @(negedge clk); set_idle(4'h0); lat_req = '0;

      // R7 / R8 lock
      @(negedge clk); win_lock = 1'b1;
      rd(12'h13C, 32'hFFFF_FFFF, "R7 locked counter read");
      rd(12'h30C, 32'hFFFF_FFFF, "R7 locked mask read");
      rd(12'h000, 32'hFFFF_FFFF, "R7 locked unmapped read");
      wr(12'h30C, 32'h0);
      @(negedge clk); win_lock = 1'b0;
      rd(12'h30C, 32'h0001_FFDF, "R8 locked write ignored");
      wr(12'h30C, 32'h0);
      rd(12'h30C, 32'h0, "R8 unlocked write applies");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule